// File: doc/BRIEF.md
# Device Address Translation Walker

This block converts addresses issued by bus-mastering devices into physical memory addresses. It uses a flat table of 32-bit entries kept in system memory. A requester hands over a device address, a byte count and a direction flag. The block splits the transfer into pieces, and no piece crosses a 4 KB page boundary. For each piece it reads one table entry through a plain memory read port, waits as long as the memory takes to answer, and checks the entry's permission bits. If the entry allows the access, the block presents the physical address and size of the piece.

When an entry refuses the access, the block records a fault word and the page-aligned device address, and abandons the remaining pieces. Every transfer ends with a one-cycle completion pulse that carries an error flag. The table location comes from `tableBase`. The size of the translated window comes from `windowStart`, a mask whose set bits are removed from the device address before the table is indexed.

Top module: `dvma_xlate`

## Requirements
- R1: `reqReady` is high only while the walker is idle; a request offered while it is busy is ignored and leaves the transfer in progress unchanged.
- R2: For each piece, the entry address on `memAddr` equals `(tableBase << 4) + (((addr & ~windowStart) >> 10) & ~3)`, truncated to 32 bits, with exactly one `memReqValid` cycle per piece.
- R3: Each piece length is the smaller of the bytes remaining in the current 4 KB page and the bytes remaining in the transfer; the next piece starts at the previous address plus that length.
- R4: The piece physical address is 36 bits, with entry bits 31:8 as bits 35:12 and the device address bits 11:0 as bits 11:0.
- R5: An entry with bit 1 (valid) clear faults the access in either direction.
- R6: A write to an entry with bit 2 (writable) clear faults; a read of such an entry, if valid, succeeds.
- R7: On a fault `faultStatus` becomes bits 31, 30, 23 and 17 set, plus bit 18 for a read (0xC0820000 for a write, 0xC0860000 for a read), `faultAddr` becomes the device address with bits 11:0 cleared, and both hold until the next fault; both are zero after reset.
- R8: A fault emits no piece for the failing page, issues no further fetches, and ends the transfer with `done` and `doneErr` high in the same cycle as `faultValid`.
- R9: A transfer without fault ends with `done` high and `doneErr` low in the cycle of its last piece; a zero-length transfer ends with `done` in the cycle after acceptance without any fetch.
- R10: The walker waits any number of cycles for `memRdValid`; after reset `reqReady` is high and `chunkValid`, `faultValid`, `done` and `memReqValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Walker idle, request taken |
| reqAddr | input | 32 | Device start address |
| reqLen | input | 16 | Byte count |
| reqWrite | input | 1 | 1 = write transfer |
| tableBase | input | 32 | Table base register value |
| windowStart | input | 32 | Window mask, cleared from the address before indexing |
| memReqValid | output | 1 | Entry fetch strobe, one cycle |
| memAddr | output | 32 | Entry address |
| memRdValid | input | 1 | Entry data returned |
| memRdData | input | 32 | Entry word |
| chunkValid | output | 1 | Piece output strobe |
| chunkPa | output | 36 | Piece physical address |
| chunkLen | output | 16 | Piece length in bytes |
| faultValid | output | 1 | Fault recorded this cycle |
| faultStatus | output | 32 | Fault word |
| faultAddr | output | 32 | Page-aligned faulting device address |
| done | output | 1 | Transfer finished |
| doneErr | output | 1 | Transfer ended by a fault |

## Verification
The hardest case to reach is a fault on a later page of a multi-page transfer. The earlier pieces must appear, and then the walker must fall silent with no extra fetch. The bench builds a table where a good page sits beside an invalid page and a read-only page. It then aims transfers that start partway into the good page and run across the boundary, in both directions, with memory latencies from zero to several cycles. A request is also held on the input for the whole of a transfer, to show that it is ignored.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  typedef struct packed {
    logic load;     // latch a new transfer
    logic capture;  // entry word present: emit piece or fault
  } dvmaStrobe_t;

  localparam int ENT_VALID_BIT = 1;
  localparam int ENT_WRITE_BIT = 2;

  localparam int FLT_ERR_BIT  = 31;
  localparam int FLT_LATE_BIT = 30;
  localparam int FLT_RSV_BIT  = 23;
  localparam int FLT_RD_BIT   = 18;
  localparam int FLT_AV_BIT   = 17;
endpackage

// File: rtl/dvma_dpath.sv
module dvma_dpath
  import dvma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PA_W       = 36,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dvmaStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [ADDR_W-1:0] windowStart,
  input  logic [31:0]       memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              zeroLen,
  output logic              lastChunk,
  output logic              entryBad,
  output logic              chunkValid,
  output logic [PA_W-1:0]   chunkPa,
  output logic [LEN_W-1:0]  chunkLen,
  output logic              faultValid,
  output logic [31:0]       faultStatus,
  output logic [ADDR_W-1:0] faultAddr
);
  localparam int PPN_W      = PA_W - PAGE_SHIFT;
  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;
  localparam int IDX_SHIFT  = PAGE_SHIFT - 2;

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic              isWrite;
  logic [LEN_W-1:0]  pageLeft;
  logic [LEN_W-1:0]  chunkSize;
  logic [31:0]       faultWord;

  always_comb begin
    pageLeft  = LEN_W'(PAGE_BYTES) - LEN_W'(curAddr[PAGE_SHIFT-1:0]);
    lastChunk = (remLen <= pageLeft);
    chunkSize = lastChunk ? remLen : pageLeft;
    zeroLen   = (reqLen == '0);
    memAddr   = (tableBase << 4)
              + (((curAddr & ~windowStart) >> IDX_SHIFT) & ~ADDR_W'(3));
    entryBad  = !memRdData[ENT_VALID_BIT]
              || (isWrite && !memRdData[ENT_WRITE_BIT]);
    faultWord = '0;
    faultWord[FLT_ERR_BIT]  = 1'b1;
    faultWord[FLT_LATE_BIT] = 1'b1;
    faultWord[FLT_RSV_BIT]  = 1'b1;
    faultWord[FLT_AV_BIT]   = 1'b1;
    faultWord[FLT_RD_BIT]   = !isWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr     <= '0;
      remLen      <= '0;
      isWrite     <= 1'b0;
      chunkValid  <= 1'b0;
      chunkPa     <= '0;
      chunkLen    <= '0;
      faultValid  <= 1'b0;
      faultStatus <= '0;
      faultAddr   <= '0;
    end else begin
      chunkValid <= 1'b0;
      faultValid <= 1'b0;
      if (strobe.load) begin
        curAddr <= reqAddr;
        remLen  <= reqLen;
        isWrite <= reqWrite;
      end else if (strobe.capture) begin
        if (entryBad) begin
          faultValid  <= 1'b1;
          faultStatus <= faultWord;
          faultAddr   <= {curAddr[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        end else begin
          chunkValid <= 1'b1;
          chunkPa    <= {memRdData[31 -: PPN_W], curAddr[PAGE_SHIFT-1:0]};
          chunkLen   <= chunkSize;
          curAddr    <= curAddr + ADDR_W'(chunkSize);
          remLen     <= remLen - chunkSize;
        end
      end
    end
  end
endmodule

// File: rtl/dvma_ctrl.sv
module dvma_ctrl
  import dvma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdValid,
  input  logic        zeroLen,
  input  logic        lastChunk,
  input  logic        entryBad,
  output logic        reqReady,
  output logic        memReqValid,
  output dvmaStrobe_t strobe,
  output logic        done,
  output logic        doneErr
);
  typedef enum logic [1:0] { ST_IDLE, ST_FETCH, ST_WAIT } walkState_t;
  walkState_t state;

  always_comb begin
    reqReady       = (state == ST_IDLE);
    memReqValid    = (state == ST_FETCH);
    strobe.load    = reqReady && reqValid;
    strobe.capture = (state == ST_WAIT) && memRdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      doneErr <= 1'b0;
    end else begin
      done    <= 1'b0;
      doneErr <= 1'b0;
      case (state)
        ST_IDLE:
          if (reqValid) begin
            if (zeroLen) done  <= 1'b1;
            else         state <= ST_FETCH;
          end
        ST_FETCH: state <= ST_WAIT;
        ST_WAIT:
          if (memRdValid) begin
            if (entryBad) begin
              done    <= 1'b1;
              doneErr <= 1'b1;
              state   <= ST_IDLE;
            end else if (lastChunk) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_FETCH;
            end
          end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PA_W       = 36,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [ADDR_W-1:0] windowStart,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [31:0]       memRdData,
  output logic              chunkValid,
  output logic [PA_W-1:0]   chunkPa,
  output logic [LEN_W-1:0]  chunkLen,
  output logic              faultValid,
  output logic [31:0]       faultStatus,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              done,
  output logic              doneErr
);
  dvmaStrobe_t strobe;
  logic zeroLen, lastChunk, entryBad;

  dvma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRdValid(memRdValid),
    .zeroLen(zeroLen), .lastChunk(lastChunk), .entryBad(entryBad),
    .reqReady(reqReady), .memReqValid(memReqValid), .strobe(strobe),
    .done(done), .doneErr(doneErr)
  );

  dvma_dpath #(.ADDR_W(ADDR_W), .PA_W(PA_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqWrite(reqWrite), .tableBase(tableBase), .windowStart(windowStart),
    .memRdData(memRdData), .memAddr(memAddr), .zeroLen(zeroLen),
    .lastChunk(lastChunk), .entryBad(entryBad), .chunkValid(chunkValid),
    .chunkPa(chunkPa), .chunkLen(chunkLen), .faultValid(faultValid),
    .faultStatus(faultStatus), .faultAddr(faultAddr)
  );
endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk #(
  parameter int ADDR_W     = 32,
  parameter int PA_W       = 36,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memReqValid,
  input logic              chunkValid,
  input logic [PA_W-1:0]   chunkPa,
  input logic [LEN_W-1:0]  chunkLen,
  input logic              faultValid,
  input logic [31:0]       faultStatus,
  input logic [ADDR_W-1:0] faultAddr,
  input logic              done,
  input logic              doneErr
);
  AST_FETCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady); // R1
  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R2
  AST_PIECE_IN_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid |-> (chunkLen != '0) &&
      ((32'(chunkPa[PAGE_SHIFT-1:0]) + 32'(chunkLen)) <= 32'(1 << PAGE_SHIFT))); // R3
  AST_FAULT_WORD: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> faultStatus[31] && faultStatus[30] && faultStatus[23] && faultStatus[17]
                   && (faultAddr[PAGE_SHIFT-1:0] == '0)); // R7
  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> $stable(faultStatus) && $stable(faultAddr)); // R7
  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> done && doneErr && !chunkValid); // R8
  AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> !memReqValid && !chunkValid); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneErr |-> done && faultValid); // R9
endmodule

bind dvma_xlate dvma_xlate_chk #(.ADDR_W(ADDR_W), .PA_W(PA_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .memReqValid(memReqValid),
  .chunkValid(chunkValid), .chunkPa(chunkPa), .chunkLen(chunkLen),
  .faultValid(faultValid), .faultStatus(faultStatus), .faultAddr(faultAddr),
  .done(done), .doneErr(doneErr)
);

// File: tb/dvma_xlate_test.sv
module dvma_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] WIN  = 32'hFF00_0000;

  // {addr, len, write, latency, expected pieces, expected error}
  localparam int NVEC = 12;
  localparam logic [56:0] VEC [NVEC] = '{
    {32'hFF00_0100, 16'h0010, 1'b0, 3'd0, 4'd1, 1'b0},
    {32'hFF00_0F00, 16'h0300, 1'b0, 3'd1, 4'd2, 1'b0},
    {32'hFF00_0F00, 16'h0300, 1'b1, 3'd2, 4'd1, 1'b1},
    {32'hFF00_3010, 16'h0004, 1'b0, 3'd3, 4'd0, 1'b1},
    {32'hFF00_2000, 16'h2000, 1'b1, 3'd0, 4'd1, 1'b1},
    {32'hFF00_4FFF, 16'h0001, 1'b0, 3'd1, 4'd1, 1'b0},
    {32'hFF00_4000, 16'h1000, 1'b1, 3'd2, 4'd1, 1'b0},
    {32'h0000_0010, 16'h0020, 1'b1, 3'd3, 4'd1, 1'b0},
    {32'hFF00_0000, 16'h0000, 1'b0, 3'd0, 4'd0, 1'b0},
    {32'hFF00_1800, 16'h0800, 1'b1, 3'd0, 4'd0, 1'b1},
    {32'hFF00_4800, 16'h1000, 1'b0, 3'd1, 4'd1, 1'b1},
    {32'hFF00_0800, 16'h2000, 1'b0, 3'd7, 4'd3, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic reqWrite = 1'b0;
  logic memReqValid;
  logic [31:0] memAddr;
  logic memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic chunkValid, faultValid, done, doneErr;
  logic [35:0] chunkPa;
  logic [15:0] chunkLen;
  logic [31:0] faultStatus, faultAddr;

  int checks = 0;
  int errors = 0;
  int latency = 0;
  int fetchCount = 0;
  logic [31:0] lastMemAddr = '0;
  logic pend = 1'b0;
  int cnt = 0;
  logic [31:0] pendAddr = '0;
  logic [31:0] tbl [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dvma_xlate uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWrite(reqWrite),
    .tableBase(BASE), .windowStart(WIN), .memReqValid(memReqValid),
    .memAddr(memAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .chunkValid(chunkValid), .chunkPa(chunkPa), .chunkLen(chunkLen),
    .faultValid(faultValid), .faultStatus(faultStatus), .faultAddr(faultAddr),
    .done(done), .doneErr(doneErr)
  );

  function automatic logic [31:0] lookup(input logic [31:0] a);
    logic [31:0] off;
    off = a - (BASE << 4);
    if (off[1:0] != 2'b00 || (off >> 2) >= 32'd16) return 32'h0;
    return tbl[off[5:2]];
  endfunction

  // memory responder: answers each fetch after `latency` extra cycles
  always @(negedge clk) begin
    memRdValid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        memRdValid <= 1'b1;
        memRdData  <= lookup(pendAddr);
        pend       <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (memReqValid) begin
      pend        <= 1'b1;
      cnt         <= latency;
      pendAddr    <= memAddr;
      lastMemAddr <= memAddr;
      fetchCount  <= fetchCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runXfer(input logic [31:0] va, input logic [15:0] len, input bit wr,
                         input int lat, input int expPieces, input bit expErr, input bit holdBusy);
    logic [31:0] eAddr, ent, eEntAddr, pageLeft, clen;
    logic [15:0] eRem;
    int pieces, f0, guard;
    bit sawFault, bad;
    eAddr = va; eRem = len; pieces = 0; sawFault = 0; guard = 0;
    latency = lat;
    f0 = fetchCount;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = va; reqLen = len; reqWrite = wr;
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (holdBusy) begin
        reqAddr = 32'hFF00_3000; reqLen = 16'h0040; reqWrite = ~wr;
      end else reqValid = 1'b0;
      guard++;
      ent      = tbl[((eAddr & ~WIN) >> 12) & 32'hF];
      if (((eAddr & ~WIN) >> 12) >= 32'd16) ent = 32'h0;
      eEntAddr = (BASE << 4) + (((eAddr & ~WIN) >> 10) & ~32'd3);
      bad      = !ent[1] || (wr && !ent[2]);
      pageLeft = 32'h1000 - {20'h0, eAddr[11:0]};
      clen     = ({16'h0, eRem} < pageLeft) ? {16'h0, eRem} : pageLeft;
      if (chunkValid) begin
        check(!bad, "R5/R6 piece on refused entry", 64'(ent), 64'(0));
        check(lastMemAddr == eEntAddr, "R2 entry address", 64'(lastMemAddr), 64'(eEntAddr));
        check(chunkPa == {ent[31:8], eAddr[11:0]}, "R4 physical address", 64'(chunkPa), 64'({ent[31:8], eAddr[11:0]}));
        check(chunkLen == clen[15:0], "R3 piece length", 64'(chunkLen), 64'(clen));
        eAddr = eAddr + clen; eRem = eRem - clen[15:0]; pieces++;
      end
      if (faultValid) begin
        sawFault = 1;
        check(bad, "R5/R6 fault on good entry", 64'(ent), 64'(0));
        check(lastMemAddr == eEntAddr, "R2 entry address at fault", 64'(lastMemAddr), 64'(eEntAddr));
        check(faultStatus == (wr ? 32'hC082_0000 : 32'hC086_0000), "R7 fault word",
              64'(faultStatus), 64'(wr ? 32'hC082_0000 : 32'hC086_0000));
        check(faultAddr == {eAddr[31:12], 12'h000}, "R7 fault address", 64'(faultAddr), 64'({eAddr[31:12], 12'h000}));
      end
      if (done) begin
        check(doneErr == expErr, "R8/R9 done error flag", 64'(doneErr), 64'(expErr));
        check(pieces == expPieces, "R3/R8 piece count", 64'(pieces), 64'(expPieces));
        check(sawFault || eRem == 0, "R9 bytes left at clean end", 64'(eRem), 64'(0));
        check(fetchCount - f0 == pieces + (sawFault ? 1 : 0), "R2/R8/R9 fetch count",
              64'(fetchCount - f0), 64'(pieces + (sawFault ? 1 : 0)));
        reqValid = 1'b0;
        break;
      end
      check(!reqReady, "R1 ready while busy", 64'(reqReady), 64'(0));
      if (guard > 500) begin
        check(0, "R10 watchdog expired", 64'(guard), 64'(500));
        reqValid = 1'b0;
        break;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) tbl[i] = 32'h0;
    tbl[0] = 32'h1234_5606;  // valid, writable
    tbl[1] = 32'h0ABC_DE02;  // valid, read only
    tbl[2] = 32'h0007_7706;  // valid, writable
    tbl[3] = 32'hFFFF_FF04;  // writable but not valid
    tbl[4] = 32'hFEDC_BA06;  // valid, writable, top page bits set

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state, R7 fault record cleared
    check(reqReady == 1'b1, "R10 reset ready", 64'(reqReady), 64'(1));
    check(!chunkValid && !faultValid && !done && !memReqValid, "R10 reset strobes",
          64'({chunkValid, faultValid, done, memReqValid}), 64'(0));
    check(faultStatus == 32'h0 && faultAddr == 32'h0, "R7 reset fault record",
          64'(faultStatus), 64'(0));

    for (int v = 0; v < NVEC; v++) begin
      runXfer(VEC[v][56:25], VEC[v][24:9], VEC[v][8], int'(VEC[v][7:5]),
              int'(VEC[v][4:1]), VEC[v][0], 1'b0);
    end

    // R7: fault record from the last faulting vector (read at 0xFF005000) held across a clean run
    runXfer(32'hFF00_0000, 16'h0040, 1'b0, 0, 1, 1'b0, 1'b0);
    check(faultStatus == 32'hC086_0000, "R7 fault word held", 64'(faultStatus), 64'(32'hC086_0000));
    check(faultAddr == 32'hFF00_5000, "R7 fault address held", 64'(faultAddr), 64'(32'hFF00_5000));

    // R1: a competing request held on the input during a transfer is ignored
    runXfer(32'hFF00_0F80, 16'h0100, 1'b0, 2, 2, 1'b0, 1'b1);
    @(negedge clk);
    check(!memReqValid && reqReady, "R1 no restart after busy request", 64'(memReqValid), 64'(0));

    // R10: long memory latency
    runXfer(32'hFF00_2FF0, 16'h0010, 1'b1, 25, 1, 1'b0, 1'b0);

    // R6: read of a read-only page succeeds end to end
    runXfer(32'hFF00_1000, 16'h1000, 1'b0, 0, 1, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R10 global watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule